// File: doc/BRIEF.md
# Packed SIMD Multimedia ALU

This block is a 64-bit packed-integer execution unit. It reads two 64-bit operands as a row of equal lanes: eight 8-bit, four 16-bit or two 32-bit. It then applies one operation to every lane in the same cycle. Carries and borrows never cross a lane boundary. Overflowing lanes can clamp to their limit instead of wrapping. Compares produce per-lane masks, so no scalar flag is needed. The unit also provides full-word logic, per-lane shifts, a 16-bit multiply, a multiply-add and a narrowing pack with saturation.

An issuing stage presents the operands, opcode, lane size, saturation mode and shift amount together. The result appears on `result` after one clock edge. The unit has no operand storage, no memory path and no decode beyond the opcode field.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high, `result` is zero at the following edge. Otherwise `result` shows the outcome of the inputs sampled at the previous rising edge.
- R2: `lsz` selects the lane width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. With `sat` at 0 or 3, opcode 0 (add) and opcode 1 (subtract) wrap modulo the lane width in each lane, and no carry or borrow moves between lanes.
- R3: With `sat` = 1, an add or subtract lane whose signed result overflows clamps to the most positive or the most negative two's-complement value of the lane.
- R4: With `sat` = 2, an add lane that carries out gives all ones, and a subtract lane that borrows gives zero.
- R5: Opcode 2 gives A AND B, opcode 3 gives (NOT A) AND B, opcode 4 gives A OR B, and opcode 5 gives A XOR B, all across the full 64 bits.
- R6: Opcode 6 is a logical left shift, opcode 7 a logical right shift and opcode 8 an arithmetic right shift, each applied per lane by `shamt`. A `shamt` of at least the lane width gives zero for the logical shifts and a copy of each lane's sign bit for the arithmetic shift.
- R7: Opcode 9 (equal) and opcode 10 (signed greater-than, A > B) set each lane to all ones when true and to all zeros when false.
- R8: Opcode 11 multiplies the four 16-bit lanes as signed values and keeps the low 16 bits of each product. `lsz` has no effect on this opcode.
- R9: Opcode 12 forms four signed 32-bit products of the 16-bit lanes. It adds products 0 and 1 into bits 31:0 and products 2 and 3 into bits 63:32, with each sum wrapping at 32 bits.
- R10: Opcode 13 packs signed lanes into lanes of half the width. `lsz` = 1 gives 16-to-8, `lsz` 2 or 3 gives 32-to-16, and `lsz` = 0 gives zero. The narrowed lanes of A fill the low 32 bits and those of B fill the high 32 bits, each in lane order. With `sat` = 2 each value clamps to the unsigned range of the narrow lane; with any other `sat` it clamps to the signed range.
- R11: Opcodes 14 and 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| op | input | 4 | Opcode |
| lsz | input | 2 | Lane size select |
| sat | input | 2 | Saturation mode for add, subtract and pack |
| shamt | input | 6 | Shift amount |
| result | output | 64 | Registered result |

## Verification
The hardest situation to reach is a single word in which some lanes saturate and their neighbours do not, at both clamp limits. This matters most in 8-bit mode, where a carry leaking across a lane boundary would be hidden by a clamp next to it. The stimulus therefore sweeps every A byte value against B words whose eight bytes all differ, covering all 256 B byte values for each A byte value, through add and subtract in every saturation mode. A further part of the stimulus walks the shift amount across all 64 values for every lane size. Mixed random and extreme operands (all-ones, lane minima and maxima) then drive every opcode, lane size and mode.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int WORD_W = 64;
    localparam int SH_W   = $clog2(WORD_W);

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_ANDN = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_CEQ  = 4'd9,
        OP_CGT  = 4'd10,
        OP_MUL  = 4'd11,
        OP_MADD = 4'd12,
        OP_PACK = 4'd13
    } simd_op_e;

    typedef enum logic [1:0] {
        LS_8   = 2'd0,
        LS_16  = 2'd1,
        LS_32  = 2'd2,
        LS_32X = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        SAT_WRAP     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2,
        SAT_WRAP_X   = 2'd3
    } sat_e;

    typedef struct packed {
        simd_op_e          op;
        lane_sz_e          lsz;
        sat_e              sat;
        logic [SH_W-1:0]   shamt;
    } simd_ctl_t;

endpackage

// File: rtl/simd_lane_unit.sv
// Per-lane add/sub (wrap or clamp), shifts and compares for one lane width.
module simd_lane_unit
    import simd_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int LW     = 8,
    parameter int SH_W   = 6
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  simd_op_e          op,
    input  sat_e              sat,
    input  logic [SH_W-1:0]   shamt,
    output logic [WORD_W-1:0] y
);
    localparam int              NL    = WORD_W / LW;
    localparam logic [LW-1:0]   SMIN  = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0]   SMAX  = ~SMIN;
    localparam logic [SH_W-1:0] LW_SH = SH_W'(LW);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] la, lb, lr;
        logic [LW:0]   sum, dif;
        logic          add_ovf, sub_ovf, wide;

        assign la   = a[i*LW +: LW];
        assign lb   = b[i*LW +: LW];
        assign sum  = {1'b0, la} + {1'b0, lb};
        assign dif  = {1'b0, la} - {1'b0, lb};
        assign wide = (shamt >= LW_SH);

        always_comb begin
            add_ovf = (la[LW-1] == lb[LW-1]) && (sum[LW-1] != la[LW-1]);
            sub_ovf = (la[LW-1] != lb[LW-1]) && (dif[LW-1] != la[LW-1]);
            case (op)
                OP_ADD: begin
                    if (sat == SAT_SIGNED && add_ovf)
                        lr = la[LW-1] ? SMIN : SMAX;
                    else if (sat == SAT_UNSIGNED && sum[LW])
                        lr = '1;
                    else
                        lr = sum[LW-1:0];
                end
                OP_SUB: begin
                    if (sat == SAT_SIGNED && sub_ovf)
                        lr = la[LW-1] ? SMIN : SMAX;
                    else if (sat == SAT_UNSIGNED && dif[LW])
                        lr = '0;
                    else
                        lr = dif[LW-1:0];
                end
                OP_SLL:  lr = wide ? '0 : (la << shamt);
                OP_SRL:  lr = wide ? '0 : (la >> shamt);
                OP_SRA:  lr = wide ? {LW{la[LW-1]}}
                                   : LW'($signed(la) >>> shamt);
                OP_CEQ:  lr = (la == lb) ? '1 : '0;
                OP_CGT:  lr = ($signed(la) > $signed(lb)) ? '1 : '0;
                default: lr = '0;
            endcase
        end

        assign y[i*LW +: LW] = lr;
    end
endmodule

// File: rtl/simd_mul16.sv
// Four signed 16x16 products: low halves, or pairwise 32-bit sums.
module simd_mul16 #(
    parameter int WORD_W = 64
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              madd,
    output logic [WORD_W-1:0] y
);
    localparam int NP = WORD_W / 16;

    logic signed [31:0] prod [NP];
    logic [WORD_W-1:0]  lo_y, sum_y;

    for (genvar i = 0; i < NP; i++) begin : g_prod
        assign prod[i] = $signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]);
        assign lo_y[i*16 +: 16] = prod[i][15:0];
    end

    for (genvar j = 0; j < NP/2; j++) begin : g_pair
        assign sum_y[j*32 +: 32] = prod[2*j] + prod[2*j+1];
    end

    assign y = madd ? sum_y : lo_y;
endmodule

// File: rtl/simd_pack.sv
// Narrowing pack of {B,A} with signed or unsigned clamping.
module simd_pack
    import simd_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  lane_sz_e          lsz,
    input  logic              uns,
    output logic [WORD_W-1:0] y
);
    logic [2*WORD_W-1:0] ab;
    logic [WORD_W-1:0]   var_y [2];

    assign ab = {b, a};

    // v = 0: 16 -> 8, v = 1: 32 -> 16
    for (genvar v = 0; v < 2; v++) begin : g_var
        localparam int DW = 8 << v;
        localparam int SW = 2 * DW;
        localparam int ND = WORD_W / DW;
        for (genvar k = 0; k < ND; k++) begin : g_dst
            logic [SW-1:0] src;
            logic [DW-1:0] dst;
            logic          s_fit, u_fit;
            assign src   = ab[k*SW +: SW];
            assign s_fit = (&src[SW-1:DW-1]) | ~(|src[SW-1:DW-1]);
            assign u_fit = ~(|src[SW-1:DW]);
            always_comb begin
                if (uns)
                    dst = u_fit ? src[DW-1:0] : (src[SW-1] ? '0 : '1);
                else
                    dst = s_fit ? src[DW-1:0]
                                : (src[SW-1] ? {1'b1, {(DW-1){1'b0}}}
                                             : {1'b0, {(DW-1){1'b1}}});
            end
            assign var_y[v][k*DW +: DW] = dst;
        end
    end

    always_comb begin
        case (lsz)
            LS_8:    y = '0;
            LS_16:   y = var_y[0];
            default: y = var_y[1];
        endcase
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int SH_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    input  logic [3:0]        op,
    input  logic [1:0]        lsz,
    input  logic [1:0]        sat,
    input  logic [5:0]        shamt,
    output logic [63:0]       result
);
    localparam int NSZ = 3;

    simd_ctl_t         ctl;
    logic [WORD_W-1:0] lane_y [NSZ];
    logic [WORD_W-1:0] lane_pick, mul_y, pack_y, nxt;

    assign ctl.op    = simd_op_e'(op);
    assign ctl.lsz   = lane_sz_e'(lsz);
    assign ctl.sat   = sat_e'(sat);
    assign ctl.shamt = shamt;

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        simd_lane_unit #(
            .WORD_W (WORD_W),
            .LW     (8 << s),
            .SH_W   (SH_W)
        ) i_lanes (
            .a     (opa),
            .b     (opb),
            .op    (ctl.op),
            .sat   (ctl.sat),
            .shamt (ctl.shamt),
            .y     (lane_y[s])
        );
    end

    simd_mul16 #(.WORD_W(WORD_W)) i_mul (
        .a    (opa),
        .b    (opb),
        .madd (ctl.op == OP_MADD),
        .y    (mul_y)
    );

    simd_pack #(.WORD_W(WORD_W)) i_pack (
        .a   (opa),
        .b   (opb),
        .lsz (ctl.lsz),
        .uns (ctl.sat == SAT_UNSIGNED),
        .y   (pack_y)
    );

    always_comb begin
        case (ctl.lsz)
            LS_8:    lane_pick = lane_y[0];
            LS_16:   lane_pick = lane_y[1];
            default: lane_pick = lane_y[2];
        endcase
    end

    always_comb begin
        case (ctl.op)
            OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_SRA,
            OP_CEQ, OP_CGT:   nxt = lane_pick;
            OP_AND:           nxt = opa & opb;
            OP_ANDN:          nxt = ~opa & opb;
            OP_OR:            nxt = opa | opb;
            OP_XOR:           nxt = opa ^ opb;
            OP_MUL, OP_MADD:  nxt = mul_y;
            OP_PACK:          nxt = pack_y;
            default:          nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= nxt;
    end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic [3:0]  op,
    input logic [1:0]  lsz,
    input logic [1:0]  sat,
    input logic [5:0]  shamt,
    input logic [63:0] result
);
    function automatic logic all_masks(input logic [63:0] v);
        for (int i = 0; i < 8; i++)
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic bytes_ge(input logic [63:0] x, input logic [63:0] y);
        for (int i = 0; i < 8; i++)
            if (x[i*8 +: 8] < y[i*8 +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [6:0] lane_w(input logic [1:0] s);
        return (s == 2'd0) ? 7'd8 : (s == 2'd1) ? 7'd16 : 7'd32;
    endfunction

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> result == '0);

    a_r4_usat_add_grows: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && sat == SAT_UNSIGNED && lsz == LS_8)
        |=> bytes_ge(result, $past(opa)));

    a_r4_usat_sub_shrinks: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUB && sat == SAT_UNSIGNED && lsz == LS_8)
        |=> bytes_ge($past(opa), result));

    a_r5_xor_word: assert property (@(posedge clk) disable iff (rst)
        (op == OP_XOR) |=> result == ($past(opa) ^ $past(opb)));

    a_r6_wide_sll_zero: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SLL && {1'b0, shamt} >= lane_w(lsz)) |=> result == '0);

    a_r7_masks_only: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CEQ || op == OP_CGT) |=> all_masks(result));

    a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (op >= 4'd14) |=> result == '0);
endmodule

bind simd_alu simd_alu_chk i_simd_alu_chk (
    .clk    (clk),
    .rst    (rst),
    .opa    (opa),
    .opb    (opb),
    .op     (op),
    .lsz    (lsz),
    .sat    (sat),
    .shamt  (shamt),
    .result (result)
);

// File: tb/test_simd_alu.sv
`timescale 1ns/1ps
module test_simd_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opa = '0, opb = '0;
    logic [3:0]  op = '0;
    logic [1:0]  lsz = '0, sat = '0;
    logic [5:0]  shamt = '0;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    simd_alu i_simd_alu (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op(op),
        .lsz(lsz), .sat(sat), .shamt(shamt), .result(result)
    );

    function automatic longint sx(input longint u, input int w);
        return (u >= (longint'(1) << (w-1))) ? u - (longint'(1) << w) : u;
    endfunction

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input int o, input int ls, input int st, input int sh);
        logic [63:0] r = '0;
        int lw = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
        longint mx = (longint'(1) << lw) - 1;
        longint hm = longint'(1) << (lw - 1);
        longint ua, ub, sa, sb, t;
        case (o)
            2: return a & b;
            3: return ~a & b;
            4: return a | b;
            5: return a ^ b;
            0, 1, 6, 7, 8, 9, 10: begin
                for (int i = 0; i < 64/lw; i++) begin
                    ua = longint'(a >> (i*lw)) & mx;
                    ub = longint'(b >> (i*lw)) & mx;
                    sa = sx(ua, lw);
                    sb = sx(ub, lw);
                    case (o)
                        0: t = (st == 1) ? clampv(sa+sb, -hm, hm-1)
                             : (st == 2) ? clampv(ua+ub, 0, mx) : ua+ub;
                        1: t = (st == 1) ? clampv(sa-sb, -hm, hm-1)
                             : (st == 2) ? clampv(ua-ub, 0, mx) : ua-ub;
                        6: t = (sh >= lw) ? 0 : ua << sh;
                        7: t = (sh >= lw) ? 0 : ua >> sh;
                        8: t = (sh >= lw) ? ((sa < 0) ? -1 : 0) : sa >>> sh;
                        9: t = (ua == ub) ? -1 : 0;
                        default: t = (sa > sb) ? -1 : 0;
                    endcase
                    r |= (64'(t & mx)) << (i*lw);
                end
                return r;
            end
            11, 12: begin
                longint p [4];
                for (int i = 0; i < 4; i++)
                    p[i] = sx(longint'(a >> (i*16)) & 16'hFFFF, 16) *
                           sx(longint'(b >> (i*16)) & 16'hFFFF, 16);
                if (o == 11) begin
                    for (int i = 0; i < 4; i++) r |= (64'(p[i] & 16'hFFFF)) << (i*16);
                end else begin
                    r = (64'((p[0] + p[1]) & 32'hFFFF_FFFF)) |
                        ((64'((p[2] + p[3]) & 32'hFFFF_FFFF)) << 32);
                end
                return r;
            end
            13: begin
                int dw, sw, nh;
                longint dmx, dhm, v;
                if (ls == 0) return '0;
                dw = (ls == 1) ? 8 : 16;
                sw = 2 * dw;
                nh = 64 / sw;
                dmx = (longint'(1) << dw) - 1;
                dhm = longint'(1) << (dw - 1);
                for (int k = 0; k < 2*nh; k++) begin
                    if (k < nh) v = longint'(a >> (k*sw));
                    else        v = longint'(b >> ((k-nh)*sw));
                    v = sx(v & ((longint'(1) << sw) - 1), sw);
                    t = (st == 2) ? clampv(v, 0, dmx) : clampv(v, -dhm, dhm-1);
                    r |= (64'(t & dmx)) << (k*dw);
                end
                return r;
            end
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input int o, input int st);
        if (o <= 1) return (st == 1) ? "R3" : (st == 2) ? "R4" : "R2";
        if (o <= 5) return "R5";
        if (o <= 8) return "R6";
        if (o <= 10) return "R7";
        if (o == 11) return "R8";
        if (o == 12) return "R9";
        if (o == 13) return "R10";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [63:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s op=%0d lsz=%0d sat=%0d sh=%0d a=%h b=%h actual=%h expected=%h",
                     req, op, lsz, sat, shamt, opa, opb, result, exp);
        end
    endtask

    // Drive at a falling edge, sample one full cycle later (one register).
    task automatic run(input logic [63:0] a, input logic [63:0] b, input int o,
                       input int ls, input int st, input int sh, input string req);
        @(negedge clk);
        opa = a; opb = b; op = 4'(o); lsz = 2'(ls); sat = 2'(st); shamt = 6'(sh);
        @(negedge clk);
        check(req, model(a, b, o, ls, st, sh));
    endtask

    function automatic logic [63:0] pick();
        logic [63:0] s [6] = '{64'h0, '1, 64'h7F7F_7FFF_7FFF_FFFF,
                               64'h8080_8000_8000_0000, 64'h7FFF_FFFF_8000_0000,
                               64'h00FF_FF00_0001_FFFE};
        if ($urandom_range(0, 2) == 0) return s[$urandom_range(0, 5)];
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds the result at zero despite busy inputs
        opa = '1; opb = 64'h1234; op = 4'd4;
        repeat (3) @(negedge clk);
        check("R1", 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", '1 | 64'h1234);

        // R2: carries stay inside lanes for every size
        for (int ls = 0; ls < 4; ls++) begin
            run('1, 64'h0101_0101_0101_0101, 0, ls, 0, 0, "R2");
            run('0, 64'h0101_0101_0101_0101, 1, ls, 3, 0, "R2");
        end

        // R2/R3/R4: every A byte against every B byte, 8-bit lanes
        for (int o = 0; o < 2; o++)
            for (int st = 0; st < 3; st++)
                for (int x = 0; x < 256; x++)
                    for (int yb = 0; yb < 32; yb++) begin
                        logic [63:0] bv;
                        for (int l = 0; l < 8; l++) bv[l*8 +: 8] = 8'(yb*8 + l);
                        run({8{8'(x)}}, bv, o, 0, st, 0, tag_of(o, st));
                    end

        // R6: every shift amount for each shift op and lane size
        for (int o = 6; o <= 8; o++)
            for (int ls = 0; ls < 4; ls++)
                for (int sh = 0; sh < 64; sh++)
                    run(pick(), 64'h0, o, ls, 0, sh, "R6");

        // R8: lsz ignored by multiply
        for (int ls = 0; ls < 4; ls++)
            run(64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFD, 11, ls, 0, 0, "R8");
        // R9: the one wrapping pair sum
        run(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 12, 0, 0, 0, "R9");
        // R10: clamp edges for each narrowing and mode
        for (int ls = 0; ls < 4; ls++)
            for (int st = 0; st < 3; st++)
                run(64'h0000_7FFF_FFFF_8000, 64'h0100_FF80_0080_007F, 13, ls, st, 0, "R10");
        // R7: equal lanes and signed ordering
        run(64'h80FF_0001_7FFF_1234, 64'h7F00_0001_8000_1234, 10, 0, 0, 0, "R7");
        run(64'h80FF_0001_7FFF_1234, 64'h7F00_0001_8000_1234, 9, 1, 0, 0, "R7");

        // Mixed sweep over every opcode, lane size and mode
        for (int o = 0; o < 16; o++)
            for (int ls = 0; ls < 4; ls++)
                for (int st = 0; st < 4; st++)
                    for (int n = 0; n < 40; n++)
                        run(pick(), pick(), o, ls, st, int'($urandom_range(0, 63)),
                            tag_of(o, st));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule